// File: doc/BRIEF.md
# ADC Pin and Settings Command Sequencer

This block sits between a host and an SPI frame engine that talks to a multi-channel converter with four general-purpose pins. It holds local copies of the converter's two configuration words: the settings word, which carries the pin output levels, the pin-readback flag, power-down and range select, and the pin configuration word, which carries the pin directions and the other pin options. A host request sets a pin level, changes a pin direction, reads a pin, or restores the power-up configuration. The block turns that request into the shortest correct series of 16-bit command frames and hands each frame to the frame engine over a request/acknowledge handshake.

Two requests often need no bus traffic at all. A read of a pin that is an output returns the locally held level. A direction change to the direction the pin already has sends no frame. Reading an input pin takes two frames. The first switches the top nibble of the reply over to the live pin states. The second switches it back, so the settings word is always left as it was.

Top module: `adc_pin_ctrl`

## Requirements
- R1: After reset the settings copy is 7'h40 (range bit 6 set, all else clear), the pin configuration copy is 12'h000, `host_ready` is 1, and neither `frm_req` nor `rsp_valid` is asserted.
- R2: A settings frame is `16'h1800 | settings`: bits 12 and 11 set, bits 15:13 and 10:7 clear, and bits 6:0 the settings copy. Within that copy, bits 3:0 are pin output levels, bit 4 asks for pin states in the reply, bit 5 is power-down and bit 6 is range select.
- R3: A pin configuration frame is `16'h4000 | config`: bit 14 set, bits 15 and 13:12 clear, and bits 11:0 the configuration copy. Bits 3:0 of that copy are pin directions, with 1 meaning output.
- R4: A set-level request (op 0) writes `host_arg` into settings bit `host_pin` and then sends exactly one settings frame.
- R5: A read (op 3) of a pin whose direction bit is 1 returns the held level of that pin and sends no frame.
- R6: A read of an input pin sends a settings frame with bit 4 set, then one with bit 4 clear. It returns bit 12+`host_pin` of the first frame's reply and leaves bit 4 of the settings copy clear.
- R7: A make-input request (op 1) sends no frame if the pin is already an input. Otherwise it clears the direction bit and sends one configuration frame.
- R8: A make-output request (op 2) first writes `host_arg` as the pin level and sends a settings frame. It then sets the direction bit and sends a configuration frame, but only if the pin was an input.
- R9: An initialise request (op 4) sends the settings frame 16'h1840 and then the configuration frame 16'h4000. Both copies end at their reset values.
- R10: Only one frame is outstanding at a time. `frm_req` stays high with `frm_word` unchanged until `frm_ack`. `host_valid` while `host_ready` is low changes neither the frames sent nor the held copies.
- R11: Every accepted request ends with `rsp_valid` high for exactly one cycle. For a read, `rsp_data` carries the pin value in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Request strobe, taken when `host_ready` is high |
| host_op | input | 3 | 0 set level, 1 make input, 2 make output, 3 read, 4 initialise |
| host_pin | input | 2 | Pin index |
| host_arg | input | 1 | Level for set-level and make-output |
| host_ready | output | 1 | Idle, can take a request |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 1 | Pin value of a read |
| frm_req | output | 1 | Frame request to the frame engine |
| frm_word | output | 16 | Command frame, stable while `frm_req` is high |
| frm_ack | input | 1 | Frame engine done; `frm_reply` valid |
| frm_reply | input | 16 | Reply word of the acknowledged frame |
| cfg_word | output | 7 | Settings copy |
| dir_word | output | 12 | Pin configuration copy |

## Verification
The embedded assertions watch the per-cycle rules on every cycle. These are the handshake hold, the single outstanding frame, the frame-kind bit patterns, the single-cycle completion pulse, the readback flag always clear when idle, and the copies staying frozen while idle with no request. Whether each request produced the right series of frames, and whether frames were skipped when a read or direction change needed none, shows only in the bench scenarios. The same holds for a read returning the reply of the right frame. The bench sweeps every pin, every level and every pin-state pattern, checks that busy-time requests are ignored, and compares each frame word against an arithmetic model.

// File: rtl/adc_pin_pkg.sv
package adc_pin_pkg;

  localparam int FRAME_W  = 16;
  localparam int CFG_W    = 7;
  localparam int GCFG_W   = 12;

  // bit positions the converter decodes
  localparam int SET_SEL_HI  = 12;
  localparam int SET_SEL_LO  = 11;
  localparam int GCFG_SEL    = 14;
  localparam int RB_BIT      = 4;
  localparam int RANGE_BIT   = 6;
  localparam int PIN_RES_LSB = 12;

  localparam logic [CFG_W-1:0]  CFG_RST  = CFG_W'(1) << RANGE_BIT;
  localparam logic [GCFG_W-1:0] GCFG_RST = '0;

  typedef enum logic [2:0] {
    OP_SET_LEVEL = 3'd0,
    OP_MAKE_IN   = 3'd1,
    OP_MAKE_OUT  = 3'd2,
    OP_READ      = 3'd3,
    OP_INIT      = 3'd4
  } host_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_DIR_OUT, S_RD_OFF, S_INIT_G, S_FIN
  } seq_st_e;

  function automatic logic [FRAME_W-1:0] settings_frame(input logic [CFG_W-1:0] c);
    logic [FRAME_W-1:0] w;
    w = '0;
    w[SET_SEL_HI] = 1'b1;
    w[SET_SEL_LO] = 1'b1;
    w[CFG_W-1:0]  = c;
    return w;
  endfunction

  function automatic logic [FRAME_W-1:0] gcfg_frame(input logic [GCFG_W-1:0] g);
    logic [FRAME_W-1:0] w;
    w = '0;
    w[GCFG_SEL]    = 1'b1;
    w[GCFG_W-1:0]  = g;
    return w;
  endfunction

  function automatic logic [CFG_W-1:0] put_cfg(input logic [CFG_W-1:0] v,
                                               input int idx, input logic b);
    logic [CFG_W-1:0] r;
    r = v;
    r[idx] = b;
    return r;
  endfunction

  function automatic logic [GCFG_W-1:0] put_gcfg(input logic [GCFG_W-1:0] v,
                                                 input int idx, input logic b);
    logic [GCFG_W-1:0] r;
    r = v;
    r[idx] = b;
    return r;
  endfunction

endpackage

// File: rtl/adc_pin_shadow.sv
module adc_pin_shadow
  import adc_pin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ld,
  input  logic [CFG_W-1:0]  cfg_d,
  input  logic              gcfg_ld,
  input  logic [GCFG_W-1:0] gcfg_d,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [GCFG_W-1:0] gcfg_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      gcfg_q <= GCFG_RST;
    end else begin
      if (cfg_ld)  cfg_q  <= cfg_d;
      if (gcfg_ld) gcfg_q <= gcfg_d;
    end
  end

endmodule

// File: rtl/adc_pin_frame_port.sv
module adc_pin_frame_port
  import adc_pin_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] word_in,
  output logic               frm_req,
  output logic [FRAME_W-1:0] frm_word,
  input  logic               frm_ack,
  input  logic [FRAME_W-1:0] frm_reply,
  output logic               done,
  output logic [FRAME_W-1:0] reply_q
);

  logic handshake;
  assign handshake = frm_req && frm_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_req  <= 1'b0;
      frm_word <= '0;
      done     <= 1'b0;
      reply_q  <= '0;
    end else begin
      done <= handshake;
      if (handshake) begin
        frm_req <= 1'b0;
        reply_q <= frm_reply;
      end
      if (start) begin
        frm_req  <= 1'b1;
        frm_word <= word_in;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    frm_req && !frm_ack |=> frm_req && $stable(frm_word)); // R10
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !frm_req); // R10

endmodule

// File: rtl/adc_pin_seq.sv
module adc_pin_seq
  import adc_pin_pkg::*;
#(
  parameter int PIN_CNT = 4,
  localparam int PIN_IW = $clog2(PIN_CNT)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_valid,
  input  logic [2:0]         host_op,
  input  logic [PIN_IW-1:0]  host_pin,
  input  logic               host_arg,
  output logic               host_ready,
  output logic               rsp_valid,
  output logic               rsp_data,
  input  logic [CFG_W-1:0]   cfg_q,
  input  logic [GCFG_W-1:0]  gcfg_q,
  output logic               cfg_ld,
  output logic [CFG_W-1:0]   cfg_d,
  output logic               gcfg_ld,
  output logic [GCFG_W-1:0]  gcfg_d,
  output logic               fr_start,
  output logic [FRAME_W-1:0] fr_word,
  input  logic               fr_done,
  input  logic [FRAME_W-1:0] fr_reply
);

  seq_st_e           st_q, st_d, fol_q, fol_d;
  logic [PIN_IW-1:0] pin_q, pin_d;
  logic              res_q, res_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      fol_q <= S_FIN;
      pin_q <= '0;
      res_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      fol_q <= fol_d;
      pin_q <= pin_d;
      res_q <= res_d;
    end
  end

  always_comb begin
    st_d     = st_q;
    fol_d    = fol_q;
    pin_d    = pin_q;
    res_d    = res_q;
    cfg_ld   = 1'b0;
    cfg_d    = cfg_q;
    gcfg_ld  = 1'b0;
    gcfg_d   = gcfg_q;
    fr_start = 1'b0;
    fr_word  = '0;
    unique case (st_q)
      S_IDLE: if (host_valid) begin
        pin_d = host_pin;
        res_d = 1'b0;
        case (host_op_e'(host_op))
          OP_SET_LEVEL, OP_MAKE_OUT: begin
            cfg_ld   = 1'b1;
            cfg_d    = put_cfg(cfg_q, int'(host_pin), host_arg);
            fr_start = 1'b1;
            fr_word  = settings_frame(cfg_d);
            st_d     = S_WAIT;
            fol_d    = (host_op_e'(host_op) == OP_MAKE_OUT) ? S_DIR_OUT : S_FIN;
          end
          OP_MAKE_IN: begin
            if (!gcfg_q[host_pin]) st_d = S_FIN;
            else begin
              gcfg_ld  = 1'b1;
              gcfg_d   = put_gcfg(gcfg_q, int'(host_pin), 1'b0);
              fr_start = 1'b1;
              fr_word  = gcfg_frame(gcfg_d);
              st_d     = S_WAIT;
              fol_d    = S_FIN;
            end
          end
          OP_READ: begin
            if (gcfg_q[host_pin]) begin
              res_d = cfg_q[host_pin];
              st_d  = S_FIN;
            end else begin
              cfg_ld   = 1'b1;
              cfg_d    = put_cfg(cfg_q, RB_BIT, 1'b1);
              fr_start = 1'b1;
              fr_word  = settings_frame(cfg_d);
              st_d     = S_WAIT;
              fol_d    = S_RD_OFF;
            end
          end
          OP_INIT: begin
            cfg_ld   = 1'b1;
            cfg_d    = CFG_RST;
            fr_start = 1'b1;
            fr_word  = settings_frame(cfg_d);
            st_d     = S_WAIT;
            fol_d    = S_INIT_G;
          end
          default: st_d = S_FIN;
        endcase
      end
      S_WAIT: if (fr_done) begin
        st_d = fol_q;
        if (fol_q == S_RD_OFF) res_d = fr_reply[PIN_RES_LSB + int'(pin_q)];
      end
      S_DIR_OUT: begin
        if (gcfg_q[pin_q]) st_d = S_FIN;
        else begin
          gcfg_ld  = 1'b1;
          gcfg_d   = put_gcfg(gcfg_q, int'(pin_q), 1'b1);
          fr_start = 1'b1;
          fr_word  = gcfg_frame(gcfg_d);
          st_d     = S_WAIT;
          fol_d    = S_FIN;
        end
      end
      S_RD_OFF: begin
        cfg_ld   = 1'b1;
        cfg_d    = put_cfg(cfg_q, RB_BIT, 1'b0);
        fr_start = 1'b1;
        fr_word  = settings_frame(cfg_d);
        st_d     = S_WAIT;
        fol_d    = S_FIN;
      end
      S_INIT_G: begin
        gcfg_ld  = 1'b1;
        gcfg_d   = GCFG_RST;
        fr_start = 1'b1;
        fr_word  = gcfg_frame(gcfg_d);
        st_d     = S_WAIT;
        fol_d    = S_FIN;
      end
      S_FIN: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  assign host_ready = (st_q == S_IDLE);
  assign rsp_valid  = (st_q == S_FIN);
  assign rsp_data   = res_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R11
  AST_NO_FRAME_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT) |-> !fr_start); // R10

endmodule

// File: rtl/adc_pin_ctrl.sv
module adc_pin_ctrl
  import adc_pin_pkg::*;
#(
  parameter int PIN_CNT = 4,
  localparam int PIN_IW = $clog2(PIN_CNT)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_valid,
  input  logic [2:0]         host_op,
  input  logic [PIN_IW-1:0]  host_pin,
  input  logic               host_arg,
  output logic               host_ready,
  output logic               rsp_valid,
  output logic               rsp_data,
  output logic               frm_req,
  output logic [FRAME_W-1:0] frm_word,
  input  logic               frm_ack,
  input  logic [FRAME_W-1:0] frm_reply,
  output logic [CFG_W-1:0]   cfg_word,
  output logic [GCFG_W-1:0]  dir_word
);

  logic               cfg_ld, gcfg_ld, fr_start, fr_done;
  logic [CFG_W-1:0]   cfg_d;
  logic [GCFG_W-1:0]  gcfg_d;
  logic [FRAME_W-1:0] fr_word, fr_reply;

  adc_pin_shadow i_shadow (
    .clk(clk), .rst_n(rst_n),
    .cfg_ld(cfg_ld), .cfg_d(cfg_d), .gcfg_ld(gcfg_ld), .gcfg_d(gcfg_d),
    .cfg_q(cfg_word), .gcfg_q(dir_word)
  );

  adc_pin_frame_port i_port (
    .clk(clk), .rst_n(rst_n),
    .start(fr_start), .word_in(fr_word),
    .frm_req(frm_req), .frm_word(frm_word),
    .frm_ack(frm_ack), .frm_reply(frm_reply),
    .done(fr_done), .reply_q(fr_reply)
  );

  adc_pin_seq #(.PIN_CNT(PIN_CNT)) i_seq (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_op(host_op), .host_pin(host_pin),
    .host_arg(host_arg), .host_ready(host_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .cfg_q(cfg_word), .gcfg_q(dir_word),
    .cfg_ld(cfg_ld), .cfg_d(cfg_d), .gcfg_ld(gcfg_ld), .gcfg_d(gcfg_d),
    .fr_start(fr_start), .fr_word(fr_word),
    .fr_done(fr_done), .fr_reply(fr_reply)
  );

  AST_SET_FRAME_FMT: assert property (@(posedge clk) disable iff (!rst_n)
    frm_req && frm_word[SET_SEL_HI] |-> frm_word[SET_SEL_LO] && !frm_word[GCFG_SEL]
      && frm_word[10:7] == 4'd0 && !frm_word[15] && !frm_word[13]); // R2
  AST_GCFG_FRAME_FMT: assert property (@(posedge clk) disable iff (!rst_n)
    frm_req && frm_word[GCFG_SEL] |-> frm_word[13:12] == 2'b00 && !frm_word[15]); // R3
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    frm_req |-> frm_word[GCFG_SEL] ^ frm_word[SET_SEL_HI]); // R2
  AST_RB_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> !cfg_word[RB_BIT]); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> !frm_req); // R10
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready && !host_valid |=> $stable(cfg_word) && $stable(dir_word)); // R10

endmodule

// File: tb/test_adc_pin_ctrl.sv
module test_adc_pin_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] OP_SET = 3'd0, OP_IN = 3'd1, OP_OUT = 3'd2,
                         OP_RD = 3'd3, OP_INI = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0;
  logic [2:0]  host_op = 3'd0;
  logic [1:0]  host_pin = 2'd0;
  logic        host_arg = 1'b0;
  logic        host_ready, rsp_valid, rsp_data, frm_req;
  logic [15:0] frm_word;
  logic        frm_ack = 1'b0;
  logic [15:0] frm_reply = 16'h0;
  logic [6:0]  cfg_word;
  logic [11:0] dir_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_pin_ctrl i_adc_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_op(host_op),
    .host_pin(host_pin), .host_arg(host_arg), .host_ready(host_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .frm_req(frm_req),
    .frm_word(frm_word), .frm_ack(frm_ack), .frm_reply(frm_reply),
    .cfg_word(cfg_word), .dir_word(dir_word)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // frame engine model
  logic [15:0] log_w [16];
  int          log_n = 0;
  int          wait_cnt = 0;
  int          lat_sel = 0;
  logic [3:0]  pins_in = 4'h0;
  bit          hold_err = 0;
  logic [15:0] first_w = 16'h0;

  initial begin
    forever begin
      @(negedge clk);
      if (frm_ack) begin
        frm_ack  = 1'b0;
        wait_cnt = 0;
      end else if (frm_req) begin
        if (wait_cnt == 0) first_w = frm_word;
        if (frm_word !== first_w) hold_err = 1;
        if (wait_cnt >= lat_sel % 3) begin
          if (log_n < 16) log_w[log_n] = frm_word;
          log_n++;
          frm_reply = (frm_word[12] && frm_word[4]) ? {pins_in, 12'h5A5} : 16'hA123;
          frm_ack   = 1'b1;
          lat_sel++;
        end else wait_cnt++;
      end
    end
  end

  // expected-value model
  logic [6:0]  cfg_m = 7'h40;
  logic [11:0] gpio_m = 12'h0;
  logic [15:0] exp_w [16];
  int          exp_n;
  logic        exp_res;

  function automatic logic [15:0] sw(input logic [6:0] c);
    return 16'h1800 | {9'd0, c};
  endfunction
  function automatic logic [15:0] gw(input logic [11:0] g);
    return 16'h4000 | {4'd0, g};
  endfunction

  task automatic model(input logic [2:0] op, input int pin, input logic arg);
    exp_n = 0;
    exp_res = 1'b0;
    case (op)
      OP_SET: begin cfg_m[pin] = arg; exp_w[exp_n++] = sw(cfg_m); end
      OP_OUT: begin
        cfg_m[pin] = arg; exp_w[exp_n++] = sw(cfg_m);
        if (!gpio_m[pin]) begin gpio_m[pin] = 1'b1; exp_w[exp_n++] = gw(gpio_m); end
      end
      OP_IN: if (gpio_m[pin]) begin gpio_m[pin] = 1'b0; exp_w[exp_n++] = gw(gpio_m); end
      OP_RD: begin
        if (gpio_m[pin]) exp_res = cfg_m[pin];
        else begin
          exp_w[exp_n++] = sw(cfg_m | 7'h10);
          exp_res = pins_in[pin];
          exp_w[exp_n++] = sw(cfg_m);
        end
      end
      default: begin
        cfg_m = 7'h40; exp_w[exp_n++] = sw(cfg_m);
        gpio_m = 12'h0; exp_w[exp_n++] = gw(gpio_m);
      end
    endcase
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input int pin, input logic arg,
                        input string tag, input bit inject);
    int guard;
    logic got;
    model(op, pin, arg);
    @(negedge clk);
    guard = 0;
    while (!host_ready && guard < 200) begin @(negedge clk); guard++; end
    log_n = 0;
    hold_err = 0;
    host_valid = 1'b1;
    host_op  = op;
    host_pin = 2'(pin);
    host_arg = arg;
    @(negedge clk);
    if (inject) begin
      // request while busy: must be ignored (R10)
      host_op  = OP_INI;
      host_pin = ~2'(pin);
      host_arg = ~arg;
      @(negedge clk);
    end
    host_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 200) begin @(negedge clk); guard++; end
    got = rsp_data;
    chk(guard < 200, tag, "completion R11", guard, 0);
    chk(log_n == exp_n, tag, "frame count", log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++)
      chk(log_w[i] == exp_w[i], tag, $sformatf("frame %0d", i), log_w[i], exp_w[i]);
    if (op == OP_RD) chk(got == exp_res, tag, "read value", got, exp_res);
    chk(cfg_word == cfg_m, tag, "settings copy", cfg_word, cfg_m);
    chk(dir_word == gpio_m, tag, "config copy", dir_word, gpio_m);
    chk(!hold_err, "R10", "word stable under req", hold_err, 0);
    @(negedge clk);
    chk(!rsp_valid, "R11", "single-cycle pulse", rsp_valid, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(cfg_word == 7'h40, "R1", "reset settings", cfg_word, 7'h40);
    chk(dir_word == 12'h0, "R1", "reset config", dir_word, 0);
    chk(host_ready == 1'b1, "R1", "reset ready", host_ready, 1);
    chk(!frm_req && !rsp_valid, "R1", "reset req/rsp", {frm_req, rsp_valid}, 0);
    rst_n = 1'b1;
    run_op(OP_INI, 0, 1'b0, "R9", 0);
    for (int p = 0; p < 4; p++)
      for (int l = 1; l >= 0; l--)
        run_op(OP_SET, p, l[0], "R4 R2", 0);
    for (int v = 0; v < 16; v++) begin
      pins_in = 4'(v);
      for (int p = 0; p < 4; p++) run_op(OP_RD, p, 1'b0, "R6", 0);
    end
    run_op(OP_OUT, 0, 1'b1, "R8 R3", 0);
    run_op(OP_OUT, 2, 1'b0, "R8 R3", 0);
    run_op(OP_OUT, 0, 1'b0, "R8", 0);
    run_op(OP_OUT, 0, 1'b1, "R8", 0);
    pins_in = 4'b1010;
    for (int p = 0; p < 4; p++) run_op(OP_RD, p, 1'b0, "R5 R6", 0);
    run_op(OP_IN, 1, 1'b0, "R7", 0);
    run_op(OP_IN, 0, 1'b0, "R7 R3", 0);
    run_op(OP_IN, 0, 1'b0, "R7", 0);
    run_op(OP_RD, 0, 1'b0, "R6", 0);
    run_op(OP_SET, 3, 1'b1, "R10", 1);
    run_op(OP_OUT, 1, 1'b1, "R10 R8", 1);
    run_op(OP_RD, 3, 1'b0, "R10 R6", 1);
    run_op(OP_INI, 0, 1'b0, "R9", 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule